// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block sequences word addresses for one channel of a two-dimensional DMA engine. A transfer covers a rectangle of memory built from lines. Each line is a run of consecutive 32-bit words. The first word of each new line sits a fixed stride of words beyond the first word of the previous line, so the stride is the line payload plus any gap between lines. All addresses are word addresses: a byte address becomes a word address when its two low bits are dropped.

One address beat is offered at a time on a valid/ready handshake. The address register can be read in any cycle, including after the transfer ends. Software can therefore work out the bytes still to move by subtracting the distance covered from the total.

A line length of zero selects ring mode. In this mode the channel walks an area of stride × (line count + 1) words one word at a time. At the end of the area it returns to the start address and carries on without stopping. It raises one event when the first half of the area is consumed and another at the end of the area. A normal transfer ends with a one-cycle done pulse. An abort returns the channel to idle from either mode.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `addr_valid`, `done`, `half_evt` and `full_evt` are 0, and `addr_out` and `dir_out` are 0.
- R2: When `start` is high in an idle cycle, `start_addr`, `line_len`, `line_cnt`, `stride` and `dir_in` are captured on that clock edge. In the next cycle `addr_valid` is 1 and `addr_out` equals `start_addr`. Later changes on those inputs have no effect until the next start.
- R3: When `line_len` is nonzero, the beats come out in this order: `line_cnt`+1 lines, each of `line_len`+1 consecutive word addresses. Line k begins at `start_addr` + k×`stride`. All arithmetic wraps modulo 2^AW.
- R4: A beat is consumed only on a clock edge where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr_out` and `addr_valid` hold, so no word is skipped or repeated.
- R5: In normal mode, `done` is high for exactly one cycle: the cycle after the last beat is accepted. In that cycle `addr_valid` is 0 and `addr_out` reads the last beat's address plus one. The value stays readable while the channel is idle.
- R6: When `line_len` is zero at start, the channel runs in ring mode over A = `stride`×(`line_cnt`+1) words (stride nonzero). Beat i has address `start_addr` + (i mod A). The channel never raises `done` in this mode.
- R7: In ring mode, `half_evt` pulses for one cycle after the beat at ring offset floor(A/2)−1 is accepted, if A ≥ 2. `full_evt` pulses for one cycle after the beat at offset A−1 is accepted. The two never pulse together.
- R8: `abort` high on a clock edge sends the channel to idle on that edge. It wins over a handshake in the same cycle. No `done` or event follows, and `addr_out` keeps its value. In an idle cycle, `abort` has no effect.
- R9: `start` while the channel is busy is ignored: the running sequence continues unchanged.
- R10: `dir_out` shows the `dir_in` captured at start (1 = memory to device, 0 = device to memory) and holds it for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| abort | input | 1 | Return to idle at once |
| start_addr | input | AW | First word address |
| line_len | input | LW | Words per line minus one; zero selects ring mode |
| line_cnt | input | CW | Lines minus one |
| stride | input | SW | Word distance between line starts |
| dir_in | input | 1 | Direction to capture at start |
| addr_ready | input | 1 | Consumer accepts the current beat |
| addr_valid | output | 1 | A beat address is on offer |
| addr_out | output | AW | Current beat address, readable at any time |
| dir_out | output | 1 | Captured direction |
| done | output | 1 | One-cycle end-of-transfer pulse |
| half_evt | output | 1 | Ring mode: first half consumed |
| full_evt | output | 1 | Ring mode: second half consumed, wrapping |

## Verification
Random normal transfers vary line length, line count, stride gap and start address. Ready is given at 100%, 70% and 30% probability, so the bench can tell stride and line-turn errors apart from handshake errors that skip or repeat words under stall.

Directed cases cover the following:
- A single-line transfer, to separate the last-column path from the last-line path.
- A transfer across the top of the address space, to expose missing modulo wrap.
- An odd ring area and a two-word ring, to test the half-event position.
- A start pulse during a busy transfer and aborts in each mode, to show that the idle/busy logic ignores or obeys them correctly.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_LINE = 2'd1,
    MODE_RING = 2'd2
  } walk_mode_e;
endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       abort,
  input  logic       ring_sel,
  input  logic       fire,
  input  logic       final_beat,
  output logic       launch,
  output walk_mode_e mode,
  output logic       done_o
);

  assign launch = start && (mode == MODE_IDLE) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort) begin
        mode <= MODE_IDLE;
      end else if (launch) begin
        mode <= ring_sel ? MODE_RING : MODE_LINE;
      end else if ((mode == MODE_LINE) && fire && final_beat) begin
        mode   <= MODE_IDLE;
        done_o <= 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
  AST_RING_NEVER_DONE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RING) |=> !done_o); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> ((mode == MODE_IDLE) && !done_o)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((mode != MODE_IDLE) && start && !abort && !(fire && final_beat)) |=>
      (mode == $past(mode))); // R9

endmodule

// File: rtl/dma2d_ring_evt.sv
module dma2d_ring_evt
  import dma2d_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [SW-1:0] stride,
  input  logic [CW-1:0] line_cnt,
  input  walk_mode_e    mode,
  input  logic          fire,
  output logic          wrap_now,
  output logic          half_evt,
  output logic          full_evt
);

  localparam int RW = SW + CW;

  logic [RW-1:0] area_q;
  logic [RW-1:0] half_q;
  logic [RW-1:0] off_q;
  logic [RW-1:0] area_new;

  assign area_new = RW'(stride) * (RW'(line_cnt) + RW'(1));
  assign wrap_now = (off_q == area_q - RW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      area_q   <= '0;
      half_q   <= '0;
      off_q    <= '0;
      half_evt <= 1'b0;
      full_evt <= 1'b0;
    end else begin
      half_evt <= 1'b0;
      full_evt <= 1'b0;
      if (launch) begin
        area_q <= area_new;
        half_q <= area_new >> 1;
        off_q  <= '0;
      end else if ((mode == MODE_RING) && fire) begin
        if (wrap_now) begin
          off_q    <= '0;
          full_evt <= 1'b1;
        end else begin
          off_q <= off_q + RW'(1);
          if ((half_q != '0) && (off_q == half_q - RW'(1))) half_evt <= 1'b1;
        end
      end
    end
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(half_evt && full_evt)); // R7
  AST_EVT_RING_ONLY: assert property (@(posedge clk) disable iff (rst)
    (half_evt || full_evt) |-> ($past(mode) == MODE_RING)); // R7

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 16,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  walk_mode_e    mode,
  input  logic          fire,
  input  logic          wrap_now,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] line_len,
  input  logic [CW-1:0] line_cnt,
  input  logic [SW-1:0] stride,
  output logic [AW-1:0] addr_q,
  output logic          final_beat
);

  logic [LW-1:0] len_q, x_q;
  logic [CW-1:0] cnt_q, y_q;
  logic [AW-1:0] stride_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] line_base_q;
  logic          last_col;
  logic          last_row;

  assign last_col   = (x_q == len_q);
  assign last_row   = (y_q == cnt_q);
  assign final_beat = last_col && last_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q       <= '0;
      cnt_q       <= '0;
      stride_q    <= '0;
      base_q      <= '0;
      line_base_q <= '0;
      x_q         <= '0;
      y_q         <= '0;
      addr_q      <= '0;
    end else if (launch) begin
      len_q       <= line_len;
      cnt_q       <= line_cnt;
      stride_q    <= AW'(stride);
      base_q      <= start_addr;
      line_base_q <= start_addr;
      x_q         <= '0;
      y_q         <= '0;
      addr_q      <= start_addr;
    end else if (fire) begin
      if (mode == MODE_RING) begin
        addr_q <= wrap_now ? base_q : addr_q + AW'(1);
      end else if (mode == MODE_LINE) begin
        if (!last_col) begin
          x_q    <= x_q + LW'(1);
          addr_q <= addr_q + AW'(1);
        end else if (!last_row) begin
          x_q         <= '0;
          y_q         <= y_q + CW'(1);
          line_base_q <= line_base_q + stride_q;
          addr_q      <= line_base_q + stride_q;
        end else begin
          addr_q <= addr_q + AW'(1);
        end
      end
    end
  end

  AST_ADDR_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    (!fire && !launch) |=> (addr_q == $past(addr_q))); // R4

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 16,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] line_len,
  input  logic [CW-1:0] line_cnt,
  input  logic [SW-1:0] stride,
  input  logic          dir_in,
  input  logic          addr_ready,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out,
  output logic          dir_out,
  output logic          done,
  output logic          half_evt,
  output logic          full_evt
);

  walk_mode_e mode;
  logic       launch;
  logic       fire;
  logic       final_beat;
  logic       wrap_now;
  logic       ring_sel;

  assign ring_sel   = (line_len == '0);
  assign addr_valid = (mode != MODE_IDLE);
  assign fire       = addr_valid && addr_ready && !abort;

  dma2d_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (abort),
    .ring_sel   (ring_sel),
    .fire       (fire),
    .final_beat (final_beat),
    .launch     (launch),
    .mode       (mode),
    .done_o     (done)
  );

  dma2d_walk #(.AW(AW), .LW(LW), .CW(CW), .SW(SW)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .mode       (mode),
    .fire       (fire),
    .wrap_now   (wrap_now),
    .start_addr (start_addr),
    .line_len   (line_len),
    .line_cnt   (line_cnt),
    .stride     (stride),
    .addr_q     (addr_out),
    .final_beat (final_beat)
  );

  dma2d_ring_evt #(.CW(CW), .SW(SW)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .stride   (stride),
    .line_cnt (line_cnt),
    .mode     (mode),
    .fire     (fire),
    .wrap_now (wrap_now),
    .half_evt (half_evt),
    .full_evt (full_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) dir_out <= 1'b0;
    else if (launch) dir_out <= dir_in;
  end

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !launch) |=> (dir_out == $past(dir_out))); // R10
  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready && !abort) |=> addr_valid); // R4
  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid); // R5

endmodule

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb_top;
  localparam int AW = 30;
  localparam int LW = 16;
  localparam int CW = 16;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] line_len = '0;
  logic [CW-1:0] line_cnt = '0;
  logic [SW-1:0] stride = '0;
  logic          dir_in = 1'b0;
  logic          addr_ready = 1'b0;
  logic          addr_valid;
  logic [AW-1:0] addr_out;
  logic          dir_out;
  logic          done;
  logic          half_evt;
  logic          full_evt;

  int vectors = 0;
  int miscompares = 0;
  int seed_v;

  dma2d_addr_gen #(.AW(AW), .LW(LW), .CW(CW), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .start_addr(start_addr), .line_len(line_len), .line_cnt(line_cnt),
    .stride(stride), .dir_in(dir_in), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .addr_out(addr_out), .dir_out(dir_out),
    .done(done), .half_evt(half_evt), .full_evt(full_evt)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_line(input logic [AW-1:0] s, input int len,
                                             input int strd, input int idx);
    int row = idx / (len + 1);
    int col = idx % (len + 1);
    return s + AW'(row * strd) + AW'(col);
  endfunction

  function automatic logic [AW-1:0] exp_ring(input logic [AW-1:0] s, input int area,
                                             input int idx);
    return s + AW'(idx % area);
  endfunction

  task automatic scramble_inputs();
    start_addr = AW'($urandom);
    line_len   = LW'($urandom);
    line_cnt   = CW'($urandom);
    stride     = SW'($urandom);
    dir_in     = 1'($urandom);
  endtask

  task automatic run_line(input logic [AW-1:0] s, input int len, input int cnt,
                          input int strd, input bit dir, input int rdy_pct,
                          input int poke_idx);
    int total = (len + 1) * (cnt + 1);
    int idx = 0;
    int guard = 0;
    bit last_rdy = 1'b1;
    @(negedge clk);
    start_addr = s; line_len = LW'(len); line_cnt = CW'(cnt);
    stride = SW'(strd); dir_in = dir; start = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    scramble_inputs(); // R2: later input changes must not matter
    chk(addr_out == s, "R2 first beat", 32'(addr_out), 32'(s));
    while (idx < total && guard < 5000) begin
      chk(addr_valid == 1'b1, "R4 valid held", 32'(addr_valid), 32'd1);
      chk(addr_out == exp_line(s, len, strd, idx), last_rdy ? "R3 order" : "R4 stall",
          32'(addr_out), 32'(exp_line(s, len, strd, idx)));
      chk(done == 1'b0, "R5 no early done", 32'(done), 32'd0);
      chk(dir_out == dir, "R10 direction", 32'(dir_out), 32'(dir));
      if (idx == poke_idx) begin
        start = 1'b1; // R9: start while busy
        line_len = LW'(len + 3); line_cnt = CW'(cnt + 2); start_addr = s + AW'(77);
      end else begin
        start = 1'b0;
      end
      last_rdy = (($urandom % 100) < 32'(rdy_pct));
      addr_ready = last_rdy;
      if (last_rdy) idx++;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    addr_ready = 1'b0;
    chk(done == 1'b1, "R5 done pulse", 32'(done), 32'd1);
    chk(addr_valid == 1'b0, "R5 idle at done", 32'(addr_valid), 32'd0);
    chk(addr_out == exp_line(s, len, strd, total - 1) + AW'(1), "R5 final readout",
        32'(addr_out), 32'(exp_line(s, len, strd, total - 1) + AW'(1)));
    @(negedge clk);
    chk(done == 1'b0, "R5 single cycle", 32'(done), 32'd0);
    chk(addr_valid == 1'b0, "R9 stays idle", 32'(addr_valid), 32'd0);
  endtask

  task automatic run_ring(input logic [AW-1:0] s, input int cnt, input int strd,
                          input int beats, input int rdy_pct);
    int area = strd * (cnt + 1);
    int half = area / 2;
    int idx = 0;
    int guard = 0;
    bit ph = 1'b0;
    bit pf = 1'b0;
    @(negedge clk);
    start_addr = s; line_len = '0; line_cnt = CW'(cnt); stride = SW'(strd);
    dir_in = 1'b1; start = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    scramble_inputs();
    while (idx < beats && guard < 8000) begin
      chk(addr_valid == 1'b1, "R6 ring valid", 32'(addr_valid), 32'd1);
      chk(addr_out == exp_ring(s, area, idx), "R6 ring address", 32'(addr_out),
          32'(exp_ring(s, area, idx)));
      chk(half_evt == ph, "R7 half event", 32'(half_evt), 32'(ph));
      chk(full_evt == pf, "R7 full event", 32'(full_evt), 32'(pf));
      chk(done == 1'b0, "R6 no done in ring", 32'(done), 32'd0);
      addr_ready = (($urandom % 100) < 32'(rdy_pct));
      if (addr_ready) begin
        ph = (half != 0) && ((idx % area) == half - 1);
        pf = ((idx % area) == area - 1);
        idx++;
      end else begin
        ph = 1'b0; pf = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    chk(half_evt == ph, "R7 half event tail", 32'(half_evt), 32'(ph));
    chk(full_evt == pf, "R7 full event tail", 32'(full_evt), 32'(pf));
    abort = 1'b1; addr_ready = 1'b1; // R8: abort wins over handshake
    @(negedge clk);
    abort = 1'b0; addr_ready = 1'b0;
    chk(addr_valid == 1'b0, "R8 ring abort idle", 32'(addr_valid), 32'd0);
    chk(addr_out == exp_ring(s, area, idx), "R8 address kept", 32'(addr_out),
        32'(exp_ring(s, area, idx)));
    chk((half_evt | full_evt | done) == 1'b0, "R8 no event after abort",
        32'({half_evt, full_evt, done}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    seed_v = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R1 reset valid", 32'(addr_valid), 32'd0);
    chk(done == 1'b0 && half_evt == 1'b0 && full_evt == 1'b0, "R1 reset pulses",
        32'({done, half_evt, full_evt}), 32'd0);
    chk(addr_out == '0 && dir_out == 1'b0, "R1 reset address", 32'(addr_out), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(addr_valid == 1'b0 && addr_out == '0, "R1 after reset", 32'(addr_out), 32'd0);

    // directed corners
    run_line(30'h0000_1000, 1, 0, 2, 1'b1, 100, -1);      // single line R3
    run_line(30'h3FFF_FFFD, 3, 2, 4, 1'b0, 100, -1);      // wrap at top, contiguous R3
    run_line(30'h0000_0200, 2, 3, 7, 1'b1, 40, 4);        // busy start poke R9
    run_ring(30'h0000_4000, 0, 3, 10, 100);               // odd area R7
    run_ring(30'h0000_5000, 1, 1, 9, 60);                 // two-word ring R7
    run_ring(30'h0000_6000, 3, 4, 40, 70);                // area 16 R6

    // abort during normal transfer R8
    @(negedge clk);
    start_addr = 30'h100; line_len = 3; line_cnt = 3; stride = 8; start = 1'b1;
    @(negedge clk);
    start = 1'b0; addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0; addr_ready = 1'b0;
    chk(addr_valid == 1'b0, "R8 line abort idle", 32'(addr_valid), 32'd0);
    chk(addr_out == 30'h103, "R8 line abort address", 32'(addr_out), 32'h103);
    @(negedge clk);
    chk(done == 1'b0, "R8 no done after abort", 32'(done), 32'd0);

    // abort while idle R8
    held = addr_out;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    chk(addr_out == held && addr_valid == 1'b0, "R8 idle abort no effect",
        32'(addr_out), 32'(held));

    // random normal transfers
    for (int n = 0; n < 24; n++) begin
      int len = 1 + int'($urandom % 4);
      int cnt = int'($urandom % 4);
      int strd = len + 1 + int'($urandom % 5);
      int pct = (n % 3 == 0) ? 100 : ((n % 3 == 1) ? 70 : 30);
      run_line(AW'($urandom), len, cnt, strd, 1'($urandom), pct,
               (n % 4 == 0) ? 2 : -1);
    end
    // random rings
    for (int n = 0; n < 8; n++) begin
      int cnt = int'($urandom % 3);
      int strd = 1 + int'($urandom % 5);
      run_ring(AW'($urandom), cnt, strd, 3 * strd * (cnt + 1) + 2, 60);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule